// File: doc/BRIEF.md
# Transmit Status Stack Register

This block holds the completion status of transmitted frames until host software has seen them. Each time the transmit MAC reports a finished frame, the block forms one status byte from the frame's outcome flags and appends it to a small first-in, first-out store. The host reads the oldest byte through a byte-wide register port. Writing any value to that port acknowledges and discards the byte.

While at least one byte waits, the block raises the transmit-complete interrupt status bit. It also tracks whether the transmitter is enabled. A fatal outcome or a status overflow turns the transmitter off, and it stays off until the host issues an enable command. A transmit reset command empties the store and leaves the transmitter disabled.

Top module: `tx_status_stack`

## Requirements
- R1: A pushed status byte has bit 7 set (transmission finished), bit 6 = completion interrupt requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 1 = reclaim error, and bits 2 and 0 clear.
- R2: The read port shows the oldest pending byte, so bytes leave in the order they were pushed.
- R3: With nothing pending the read port shows 0x00.
- R4: A host write, whatever its data, removes the oldest pending byte. A write while nothing is pending changes nothing.
- R5: `tx_complete` is high exactly while at least one byte is pending.
- R6: A push that arrives while all DEPTH entries are occupied, with no pop in the same cycle, is dropped. It sets bit 2 (status overflow) in the newest stored byte and disables the transmitter.
- R7: A finished frame that carries maximum collisions, underrun, jabber or reclaim error disables the transmitter. A frame without these flags leaves the enable state unchanged.
- R8: The enable command sets `tx_enabled`. If a disabling event occurs in the same cycle, the disable wins. After reset the transmitter is disabled.
- R9: The transmit reset command empties the store and disables the transmitter. It overrides pushes, pops and enables in the same cycle.
- R10: A push and a pop in the same cycle both take effect, including when the store is full. In that case no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_done | input | 1 | One-cycle pulse: a frame has finished |
| fl_intreq | input | 1 | Completion interrupt requested for this frame |
| fl_jabber | input | 1 | Jabber outcome |
| fl_underrun | input | 1 | Underrun outcome |
| fl_maxcoll | input | 1 | Abandoned after maximum collisions |
| fl_reclaim | input | 1 | Reclaim error outcome |
| host_wr | input | 1 | Host write strobe to the status register (pop) |
| host_wdata | input | 8 | Host write data (ignored) |
| cmd_tx_enable | input | 1 | Transmitter enable command |
| cmd_tx_reset | input | 1 | Transmit reset command |
| rd_data | output | 8 | Oldest pending status byte, 0x00 when none |
| tx_complete | output | 1 | Transmit-complete interrupt status |
| tx_enabled | output | 1 | Transmitter enable state |

## Verification
A frame completion and a host acknowledge can land in the same cycle. This matters most when the store is full, because the outcome then decides between an overflow mark and a normal append. The bench drives `frame_done` and `host_wr` together, once on an empty store and once on a full one. It then drains every entry and compares each byte and the final count against a queue model that pops before it appends. The enable command is also driven in the same cycle as a disabling frame, and the bench checks that `tx_enabled` ends up low.

// File: rtl/tx_status_stack.sv
module tx_status_stack #(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_done,
  input  logic       fl_intreq,
  input  logic       fl_jabber,
  input  logic       fl_underrun,
  input  logic       fl_maxcoll,
  input  logic       fl_reclaim,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  input  logic       cmd_tx_enable,
  input  logic       cmd_tx_reset,
  output logic [7:0] rd_data,
  output logic       tx_complete,
  output logic       tx_enabled
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, last_ptr;
  logic [CW-1:0] count;

  wire empty   = (count == '0);
  wire full    = (count == CW'(DEPTH));
  wire pop     = host_wr && !empty;
  wire overrun = frame_done && full && !pop;
  wire push    = frame_done && !overrun;
  wire fatal   = frame_done && (fl_maxcoll || fl_underrun || fl_jabber || fl_reclaim);
  wire [7:0] status_byte = {1'b1, fl_intreq, fl_jabber, fl_underrun,
                            fl_maxcoll, 1'b0, fl_reclaim, 1'b0};

  wire unused_ok = ^host_wdata;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign last_ptr    = (wr_ptr == '0) ? AW'(DEPTH - 1) : wr_ptr - 1'b1;
  assign rd_data     = empty ? 8'h00 : mem[rd_ptr];
  assign tx_complete = !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (cmd_tx_reset) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!cmd_tx_reset) begin
      if (push)         mem[wr_ptr]   <= status_byte;
      else if (overrun) mem[last_ptr] <= mem[last_ptr] | 8'h04;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     tx_enabled <= 1'b0;
    else if (cmd_tx_reset)          tx_enabled <= 1'b0;
    else if (fatal || overrun)      tx_enabled <= 1'b0;
    else if (cmd_tx_enable)         tx_enabled <= 1'b1;
  end
endmodule

module tx_status_stack_chk #(
  parameter int DEPTH = 32,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_done,
  input logic          fl_jabber,
  input logic          fl_underrun,
  input logic          fl_maxcoll,
  input logic          fl_reclaim,
  input logic          host_wr,
  input logic          cmd_tx_enable,
  input logic          cmd_tx_reset,
  input logic [7:0]    rd_data,
  input logic          tx_complete,
  input logic          tx_enabled,
  input logic [CW-1:0] count
);
  a_r3_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_complete |-> rd_data == 8'h00);

  a_r1_done_bit: assert property (@(posedge clk) disable iff (!rst_n)
    tx_complete |-> rd_data[7] && !rd_data[0]);

  a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_tx_reset |=> !tx_complete && !tx_enabled);

  a_r7_fatal_disables: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && (fl_maxcoll || fl_underrun || fl_jabber || fl_reclaim) |=> !tx_enabled);

  a_r8_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_tx_enable && !frame_done && !cmd_tx_reset |=> tx_enabled);

  a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !host_wr && !cmd_tx_reset && count == CW'(DEPTH)
    |=> count == CW'(DEPTH) && !tx_enabled);

  a_r4_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !frame_done && !cmd_tx_reset && tx_complete
    |=> count == $past(count) - 1'b1);

  a_r10_both_keep: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && frame_done && !cmd_tx_reset && tx_complete
    |=> $stable(count));
endmodule

bind tx_status_stack tx_status_stack_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .fl_jabber(fl_jabber),
  .fl_underrun(fl_underrun), .fl_maxcoll(fl_maxcoll), .fl_reclaim(fl_reclaim),
  .host_wr(host_wr), .cmd_tx_enable(cmd_tx_enable), .cmd_tx_reset(cmd_tx_reset),
  .rd_data(rd_data), .tx_complete(tx_complete), .tx_enabled(tx_enabled),
  .count(count));

// File: tb/tx_status_stack_test.sv
module tx_status_stack_test;
  localparam int DEPTH = 32;

  logic clk = 0, rst_n = 0;
  logic frame_done = 0, fl_intreq = 0, fl_jabber = 0, fl_underrun = 0;
  logic fl_maxcoll = 0, fl_reclaim = 0, host_wr = 0;
  logic [7:0] host_wdata = 0;
  logic cmd_tx_enable = 0, cmd_tx_reset = 0;
  logic [7:0] rd_data;
  logic tx_complete, tx_enabled;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic exp_en = 0;

  always #2 clk = ~clk;

  tx_status_stack #(.DEPTH(DEPTH)) uut (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    chk(req, "rd_data", rd_data, exp_q.size() ? exp_q[0] : 8'h00);
    chk(req, "tx_complete", tx_complete, exp_q.size() != 0);
    chk(req, "tx_enabled", tx_enabled, exp_en);
  endtask

  // flags: {intreq, jabber, underrun, maxcoll, reclaim}
  task automatic step(string req, bit push, logic [4:0] fl, bit pop,
                      bit en, bit rst, logic [7:0] wd = 8'h5A);
    bit pop_ok, dis;
    @(negedge clk);
    frame_done = push; {fl_intreq, fl_jabber, fl_underrun, fl_maxcoll, fl_reclaim} = fl;
    host_wr = pop; host_wdata = wd; cmd_tx_enable = en; cmd_tx_reset = rst;
    if (rst) begin
      exp_q.delete(); exp_en = 0;
    end else begin
      dis = push && (fl[3:0] != 0);
      pop_ok = pop && exp_q.size() > 0;
      if (push && exp_q.size() == DEPTH && !pop_ok) begin
        exp_q[exp_q.size()-1] |= 8'h04; dis = 1;
      end else begin
        if (pop_ok) void'(exp_q.pop_front());
        if (push) exp_q.push_back({1'b1, fl[4], fl[3], fl[2], fl[1], 1'b0, fl[0], 1'b0});
      end
      if (dis) exp_en = 0; else if (en) exp_en = 1;
    end
    @(negedge clk);
    {frame_done, host_wr, cmd_tx_enable, cmd_tx_reset} = '0;
    compare(req);
  endtask

  initial begin
    #20000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R3_reset");
    rst_n = 1;
    step("R8", 0, 0, 0, 1, 0);
    step("R1", 1, 5'b10000, 0, 0, 0);
    step("R1", 1, 5'b00000, 0, 0, 0);
    step("R5", 1, 5'b10000, 0, 0, 0);
    chk("R5", "pending", tx_complete, 1);
    for (int i = 0; i < 3; i++) step("R2_R4", 0, 0, 1, 0, 0, 8'(i * 37));
    step("R4_empty", 0, 0, 1, 0, 0);
    step("R3", 1, 5'b00000, 0, 0, 0);
    step("R4", 0, 0, 1, 0, 0);
    step("R7_underrun", 1, 5'b00100, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 0);
    step("R7_jabber", 1, 5'b01000, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 0);
    step("R7_maxcoll", 1, 5'b00010, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 0);
    step("R7_reclaim", 1, 5'b00001, 0, 0, 0);
    step("R8_same_cycle", 1, 5'b00010, 0, 1, 0);
    step("R8", 0, 0, 0, 1, 0);
    for (int i = 0; i < 6; i++) step("R4", 0, 0, 1, 0, 0);
    step("R10_empty", 1, 5'b10000, 1, 0, 0);
    step("R4", 0, 0, 1, 0, 0);
    for (int i = 0; i < DEPTH; i++) step("R6_fill", 1, 5'(i[0] ? 5'b10000 : 0), 0, 0, 0);
    step("R6_overflow", 1, 5'b10000, 0, 0, 0);
    chk("R6", "newest overflow bit", exp_q[DEPTH-1][2], 1);
    for (int i = 0; i < DEPTH; i++) step("R6_drain", 0, 0, 1, 0, 0);
    chk("R6", "drained", tx_complete, 0);
    step("R8", 0, 0, 0, 1, 0);
    for (int i = 0; i < DEPTH; i++) step("R10_fill", 1, 5'(i % 3 == 0 ? 5'b10000 : 0), 0, 0, 0);
    step("R10_full", 1, 5'b10000, 1, 0, 0);
    chk("R10", "enabled kept", tx_enabled, 1);
    for (int i = 0; i < DEPTH; i++) step("R10_drain", 0, 0, 1, 0, 0);
    step("R1", 1, 5'b00000, 0, 0, 0);
    step("R1", 1, 5'b10000, 0, 0, 0);
    step("R9", 1, 5'b00000, 1, 1, 1);
    step("R9_after", 0, 0, 1, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule